// File: doc/BRIEF.md
# Wavefront Execute-Mask Controller

This block keeps the lane-enable state of one 64-lane wavefront. The wavefront runs on a 16-lane vector unit, so each vector instruction takes four back-to-back quarter cycles. Divergent control flow is handled with explicit scalar mask instructions rather than a hardware reconvergence stack. A vector compare packs one bit per active lane into a 64-bit scalar pair. A save-and-narrow operation stores the live mask and ANDs it with a condition. An invert-against-saved operation switches execution to the other side of the branch. A plain move restores the mask once the conditional region ends. A branch-if-empty test reports when no lane is left active, so the guarded block can be skipped.

During a vector ALU instruction the controller drives a per-lane write enable for the 16 lanes of the current quarter. Disabled lanes keep their old register contents. Scalar mask operations finish in one cycle. Any mask change is therefore in place before quarter 0 of the next vector instruction.

The sequencer has three states. IDLE accepts issues. CMP_RUN and ALU_RUN each last four cycles with a quarter counter running 0 to 3. The transition IDLE→CMP_RUN happens on a compare issue and IDLE→ALU_RUN on an ALU issue. The transitions CMP_RUN→IDLE and ALU_RUN→IDLE happen after quarter 3. Otherwise each run state stays in place and the quarter counter advances.

Top module: `exec_mask_ctrl`

## Requirements
- R1: After reset the execute mask is all ones, the condition bit is 0, every scalar pair reads 0, the write enables are 0, busy is 0 and no branch is reported.
- R2: A vector instruction (operation code 1 = compare, 2 = ALU) issued from idle makes `busy` high for exactly four cycles starting the next cycle. `quarter` reads 0, 1, 2, 3 in those cycles, and quarter q covers lanes 16q to 16q+15.
- R3: During quarter q of an ALU instruction, `wb_en[i]` equals execute-mask bit 16q+i. Outside ALU quarters, including compare quarters and idle cycles, `wb_en` is 0.
- R4: A compare writes `lane_cmp[i]` ANDed with execute-mask bit 16q+i into bit 16q+i of destination pair `issue_dst`, one quarter per cycle. Lanes that are inactive store 0.
- R5: Save-and-narrow (code 3) writes the old mask into pair `issue_dst`. It sets the mask to the old mask ANDed with pair `issue_src`, and sets the condition bit to 1 exactly when the new mask is non-zero. All of this happens in the cycle after issue.
- R6: Invert-against-saved (code 4) sets the mask to pair `issue_src` ANDed with the inverse of the current mask, and sets the condition bit to 1 exactly when the result is non-zero.
- R7: Move (code 5) copies pair `issue_src` into the mask and leaves the condition bit unchanged.
- R8: Branch-if-empty (code 6) raises `br_valid` for one cycle, the cycle after issue. In that cycle `br_taken` is 1 exactly when the execute mask is all zero.
- R9: Issues that arrive while a vector instruction is in progress are ignored, and the execute mask does not change in any of the four quarters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Instruction issue strobe |
| issue_op | input | 3 | Operation code (0 none, 1 compare, 2 ALU, 3 save-and-narrow, 4 invert-against-saved, 5 move, 6 branch-if-empty) |
| issue_dst | input | 3 | Destination scalar pair |
| issue_src | input | 3 | Source scalar pair |
| lane_cmp | input | 16 | Raw compare result of the current quarter |
| rd_addr | input | 3 | Scalar pair read select |
| quarter | output | 2 | Current quarter of the running vector instruction |
| busy | output | 1 | Vector instruction in progress |
| wb_en | output | 16 | Per-lane writeback enable of the current quarter |
| exec_mask | output | 64 | Execute mask |
| scc | output | 1 | Scalar condition bit |
| br_valid | output | 1 | Branch decision strobe |
| br_taken | output | 1 | Branch taken (mask empty) |
| rd_data | output | 64 | Contents of the selected scalar pair |

## Verification
Some rules are checked by assertions on every cycle:
- the quarter counter steps in order and a run ends after quarter 3;
- the mask holds while busy;
- no more lanes are enabled than the mask holds;
- the condition bit matches the mask after a narrowing or inverting operation;
- a taken branch sees an empty mask.

Only the bench scenarios can show the values themselves. The bench runs nested if/else sequences over many mask and condition patterns. Those patterns include empty, full, single-lane and single-quarter masks. The scenarios show that inactive lanes read 0 in compare results, that the saved mask round-trips through the pair file, and that an issue injected mid-instruction leaves no trace.

// File: rtl/exm_pkg.sv
package exm_pkg;

    typedef enum logic [2:0] {
        OP_NOP     = 3'd0,
        OP_VCMP    = 3'd1,
        OP_VALU    = 3'd2,
        OP_SAVEAND = 3'd3,
        OP_ANDNOT  = 3'd4,
        OP_MOVE    = 3'd5,
        OP_BRZ     = 3'd6,
        OP_RSV     = 3'd7
    } exm_op_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_CMP_RUN = 2'd1,
        ST_ALU_RUN = 2'd2
    } exm_st_e;

endpackage

// File: rtl/exm_seq.sv
module exm_seq
    import exm_pkg::*;
#(
    parameter int QUARTERS = 4,
    parameter int QW       = 2,
    parameter int AW       = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue_valid,
    input  logic [2:0]    issue_op,
    input  logic [AW-1:0] issue_dst,
    output logic          busy,
    output logic          cmp_on,
    output logic          alu_on,
    output logic [QW-1:0] quarter,
    output logic [AW-1:0] cmp_dst,
    output logic          scalar_fire
);

    localparam logic [QW-1:0] LAST_Q = QW'(QUARTERS - 1);

    exm_st_e       state_q, state_d;
    logic [QW-1:0] qcnt_q, qcnt_d;
    logic [AW-1:0] dst_q;
    logic          start;
    exm_op_e       op;

    assign op = exm_op_e'(issue_op);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            qcnt_q  <= '0;
            dst_q   <= '0;
        end else begin
            state_q <= state_d;
            qcnt_q  <= qcnt_d;
            if (start) dst_q <= issue_dst;
        end
    end

    always_comb begin
        state_d = state_q;
        qcnt_d  = qcnt_q;
        start   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (issue_valid && op == OP_VCMP) begin
                    state_d = ST_CMP_RUN;
                    qcnt_d  = '0;
                    start   = 1'b1;
                end else if (issue_valid && op == OP_VALU) begin
                    state_d = ST_ALU_RUN;
                    qcnt_d  = '0;
                    start   = 1'b1;
                end
            end
            ST_CMP_RUN, ST_ALU_RUN: begin
                if (qcnt_q == LAST_Q) begin
                    state_d = ST_IDLE;
                    qcnt_d  = '0;
                end else begin
                    qcnt_d = qcnt_q + 1'b1;
                end
            end
            default: begin
                state_d = ST_IDLE;
                qcnt_d  = '0;
            end
        endcase
    end

    always_comb begin
        busy        = (state_q != ST_IDLE);
        cmp_on      = (state_q == ST_CMP_RUN);
        alu_on      = (state_q == ST_ALU_RUN);
        quarter     = qcnt_q;
        cmp_dst     = dst_q;
        scalar_fire = (state_q == ST_IDLE) && issue_valid &&
                      (op == OP_SAVEAND || op == OP_ANDNOT ||
                       op == OP_MOVE    || op == OP_BRZ);
    end

    AST_QUARTER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && qcnt_q != LAST_Q) |=> (qcnt_q == $past(qcnt_q) + 1'b1)); // R2
    AST_RUN_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && qcnt_q == LAST_Q) |=> (state_q == ST_IDLE)); // R2

endmodule

// File: rtl/exm_sregs.sv
module exm_sregs #(
    parameter int LANES  = 64,
    parameter int SIMD_W = 16,
    parameter int NPAIR  = 8,
    parameter int AW     = 3,
    parameter int QW     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_on,
    input  logic [AW-1:0]     cmp_dst,
    input  logic [QW-1:0]     quarter,
    input  logic [SIMD_W-1:0] cmp_bits,
    input  logic              save_we,
    input  logic [AW-1:0]     save_dst,
    input  logic [LANES-1:0]  save_val,
    input  logic [AW-1:0]     src_addr,
    output logic [LANES-1:0]  src_val,
    input  logic [AW-1:0]     rd_addr,
    output logic [LANES-1:0]  rd_val
);

    logic [LANES-1:0] pair_q [NPAIR];

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pair_q[p] <= '0;
            end else if (save_we && save_dst == AW'(p)) begin
                pair_q[p] <= save_val;
            end else if (cmp_on && cmp_dst == AW'(p)) begin
                pair_q[p][int'(quarter)*SIMD_W +: SIMD_W] <= cmp_bits;
            end
        end
    end

    assign src_val = pair_q[src_addr];
    assign rd_val  = pair_q[rd_addr];

endmodule

// File: rtl/exm_mask.sv
module exm_mask
    import exm_pkg::*;
#(
    parameter int LANES = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  logic [2:0]       op_raw,
    input  logic [LANES-1:0] src_val,
    output logic [LANES-1:0] exec,
    output logic             scc,
    output logic             br_valid,
    output logic             br_taken
);

    exm_op_e          op;
    logic [LANES-1:0] exec_q, exec_d;
    logic             scc_q, scc_d;
    logic             brv_q, brt_q;

    assign op = exm_op_e'(op_raw);

    always_comb begin
        exec_d = exec_q;
        scc_d  = scc_q;
        if (fire) begin
            unique case (op)
                OP_SAVEAND: begin
                    exec_d = exec_q & src_val;
                    scc_d  = |exec_d;
                end
                OP_ANDNOT: begin
                    exec_d = src_val & ~exec_q;
                    scc_d  = |exec_d;
                end
                OP_MOVE: exec_d = src_val;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exec_q <= '1;
            scc_q  <= 1'b0;
            brv_q  <= 1'b0;
            brt_q  <= 1'b0;
        end else begin
            exec_q <= exec_d;
            scc_q  <= scc_d;
            brv_q  <= fire && op == OP_BRZ;
            brt_q  <= fire && op == OP_BRZ && exec_q == '0;
        end
    end

    assign exec     = exec_q;
    assign scc      = scc_q;
    assign br_valid = brv_q;
    assign br_taken = brt_q;

    AST_SCC_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && (op == OP_SAVEAND || op == OP_ANDNOT)) |=> (scc_q == (exec_q != '0))); // R5
    AST_BR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        brt_q |-> (brv_q && exec_q == '0)); // R8

endmodule

// File: rtl/exm_lane_gate.sv
module exm_lane_gate #(
    parameter int LANES  = 64,
    parameter int SIMD_W = 16,
    parameter int QW     = 2
) (
    input  logic [LANES-1:0]  exec,
    input  logic [QW-1:0]     quarter,
    input  logic              alu_on,
    input  logic [SIMD_W-1:0] lane_cmp,
    output logic [SIMD_W-1:0] wb_en,
    output logic [SIMD_W-1:0] cmp_bits
);

    logic [SIMD_W-1:0] slice;

    assign slice = exec[int'(quarter)*SIMD_W +: SIMD_W];

    for (genvar i = 0; i < SIMD_W; i++) begin : g_lane
        assign wb_en[i]    = alu_on & slice[i];
        assign cmp_bits[i] = lane_cmp[i] & slice[i];
    end

endmodule

// File: rtl/exec_mask_ctrl.sv
module exec_mask_ctrl
    import exm_pkg::*;
#(
    parameter  int LANES    = 64,
    parameter  int SIMD_W   = 16,
    parameter  int NPAIR    = 8,
    localparam int QUARTERS = LANES / SIMD_W,
    localparam int QW       = (QUARTERS > 1) ? $clog2(QUARTERS) : 1,
    localparam int AW       = (NPAIR > 1) ? $clog2(NPAIR) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_valid,
    input  logic [2:0]        issue_op,
    input  logic [AW-1:0]     issue_dst,
    input  logic [AW-1:0]     issue_src,
    input  logic [SIMD_W-1:0] lane_cmp,
    input  logic [AW-1:0]     rd_addr,
    output logic [QW-1:0]     quarter,
    output logic              busy,
    output logic [SIMD_W-1:0] wb_en,
    output logic [LANES-1:0]  exec_mask,
    output logic              scc,
    output logic              br_valid,
    output logic              br_taken,
    output logic [LANES-1:0]  rd_data
);

    logic              cmp_on, alu_on, scalar_fire, save_we;
    logic [AW-1:0]     cmp_dst;
    logic [SIMD_W-1:0] cmp_bits;
    logic [LANES-1:0]  src_val;

    assign save_we = scalar_fire && issue_op == OP_SAVEAND;

    exm_seq #(.QUARTERS(QUARTERS), .QW(QW), .AW(AW)) u_seq (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_op(issue_op),
        .issue_dst(issue_dst), .busy(busy), .cmp_on(cmp_on), .alu_on(alu_on),
        .quarter(quarter), .cmp_dst(cmp_dst), .scalar_fire(scalar_fire)
    );

    exm_sregs #(.LANES(LANES), .SIMD_W(SIMD_W), .NPAIR(NPAIR), .AW(AW), .QW(QW)) u_sregs (
        .clk(clk), .rst_n(rst_n), .cmp_on(cmp_on), .cmp_dst(cmp_dst), .quarter(quarter),
        .cmp_bits(cmp_bits), .save_we(save_we), .save_dst(issue_dst), .save_val(exec_mask),
        .src_addr(issue_src), .src_val(src_val), .rd_addr(rd_addr), .rd_val(rd_data)
    );

    exm_mask #(.LANES(LANES)) u_mask (
        .clk(clk), .rst_n(rst_n), .fire(scalar_fire), .op_raw(issue_op), .src_val(src_val),
        .exec(exec_mask), .scc(scc), .br_valid(br_valid), .br_taken(br_taken)
    );

    exm_lane_gate #(.LANES(LANES), .SIMD_W(SIMD_W), .QW(QW)) u_gate (
        .exec(exec_mask), .quarter(quarter), .alu_on(alu_on), .lane_cmp(lane_cmp),
        .wb_en(wb_en), .cmp_bits(cmp_bits)
    );

    AST_EXEC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(exec_mask)); // R9
    AST_WB_WITHIN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(wb_en) <= $countones(exec_mask)); // R3
    AST_IDLE_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (wb_en == '0)); // R3

endmodule

// File: tb/exec_mask_ctrl_tb.sv
module exec_mask_ctrl_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_valid = 1'b0;
    logic [2:0]  issue_op = '0;
    logic [2:0]  issue_dst = '0;
    logic [2:0]  issue_src = '0;
    logic [15:0] lane_cmp = '0;
    logic [2:0]  rd_addr = '0;
    logic [1:0]  quarter;
    logic        busy;
    logic [15:0] wb_en;
    logic [63:0] exec_mask;
    logic        scc;
    logic        br_valid;
    logic        br_taken;
    logic [63:0] rd_data;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [63:0] exec_m;
    logic [63:0] sreg_m [8];
    logic        scc_m;

    always #(CLK_PERIOD/2) clk = ~clk;

    exec_mask_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_op(issue_op),
        .issue_dst(issue_dst), .issue_src(issue_src), .lane_cmp(lane_cmp), .rd_addr(rd_addr),
        .quarter(quarter), .busy(busy), .wb_en(wb_en), .exec_mask(exec_mask), .scc(scc),
        .br_valid(br_valid), .br_taken(br_taken), .rd_data(rd_data)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] pat(int k);
        logic [63:0] h;
        h = 64'h9E3779B97F4A7C15 * 64'(k + 1);
        case (k % 6)
            0:       return 64'd0;
            1:       return '1;
            2:       return 64'd1 << (k % 64);
            3:       return 64'hFFFF << (16 * (k % 4));
            4:       return h;
            default: return ~(64'd1 << (k % 64));
        endcase
    endfunction

    task automatic do_vec(input logic [2:0] op, input logic [2:0] dst,
                          input logic [63:0] lanes, input bit inject);
        @(negedge clk);
        issue_valid = 1'b1; issue_op = op; issue_dst = dst;
        for (int q = 0; q < 4; q++) begin
            @(negedge clk);
            if (inject && q == 1) begin
                issue_valid = 1'b1; issue_op = 3'd5; issue_src = 3'd0;
            end else begin
                issue_valid = 1'b0;
            end
            lane_cmp = lanes[q*16 +: 16];
            chk("R2 quarter", 64'(quarter), 64'(q));
            chk("R2 busy", 64'(busy), 64'd1);
            chk("R3 wb_en", 64'(wb_en), (op == 3'd2) ? 64'(exec_m[q*16 +: 16]) : 64'd0);
        end
        @(negedge clk);
        issue_valid = 1'b0;
        if (op == 3'd1) sreg_m[dst] = lanes & exec_m;
        chk("R2 run over", 64'(busy), 64'd0);
        chk("R9 mask held", exec_mask, exec_m);
        if (op == 3'd1) begin
            rd_addr = dst;
            #1;
            chk("R4 compare pair", rd_data, sreg_m[dst]);
        end
    endtask

    task automatic do_sc(input logic [2:0] op, input logic [2:0] dst, input logic [2:0] src);
        logic [63:0] old_m, s;
        old_m = exec_m;
        s = sreg_m[src];
        @(negedge clk);
        issue_valid = 1'b1; issue_op = op; issue_dst = dst; issue_src = src;
        @(negedge clk);
        issue_valid = 1'b0;
        case (op)
            3'd3: begin sreg_m[dst] = old_m; exec_m = old_m & s; scc_m = |exec_m; end
            3'd4: begin exec_m = s & ~old_m; scc_m = |exec_m; end
            3'd5: exec_m = s;
            default: ;
        endcase
        case (op)
            3'd3: begin
                chk("R5 mask", exec_mask, exec_m);
                chk("R5 scc", 64'(scc), 64'(scc_m));
                rd_addr = dst;
                #1;
                chk("R5 saved pair", rd_data, sreg_m[dst]);
            end
            3'd4: begin
                chk("R6 mask", exec_mask, exec_m);
                chk("R6 scc", 64'(scc), 64'(scc_m));
            end
            3'd5: begin
                chk("R7 mask", exec_mask, exec_m);
                chk("R7 scc kept", 64'(scc), 64'(scc_m));
            end
            3'd6: begin
                chk("R8 valid", 64'(br_valid), 64'd1);
                chk("R8 taken", 64'(br_taken), 64'(old_m == 64'd0));
                @(negedge clk);
                chk("R8 one cycle", 64'(br_valid), 64'd0);
            end
            default: ;
        endcase
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        exec_m = '1;
        scc_m  = 1'b0;
        for (int p = 0; p < 8; p++) sreg_m[p] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 mask", exec_mask, '1);
        chk("R1 scc", 64'(scc), 64'd0);
        chk("R1 wb_en", 64'(wb_en), 64'd0);
        chk("R1 busy", 64'(busy), 64'd0);
        chk("R1 branch", 64'(br_valid), 64'd0);
        for (int p = 0; p < 8; p++) begin
            rd_addr = 3'(p);
            #1;
            chk("R1 pair", rd_data, 64'd0);
        end
        // pair 0 holds all ones for restoring a full mask
        do_vec(3'd1, 3'd0, '1, 1'b0);
        for (int i = 0; i < 48; i++) begin
            logic [63:0] outer, cond;
            outer = pat(i);
            cond  = pat(i * 5 + 3);
            do_sc(3'd5, 3'd0, 3'd0);            // R7 full mask
            do_vec(3'd1, 3'd1, outer, 1'b0);     // R4 under full mask
            do_sc(3'd5, 3'd0, 3'd1);             // R7 mask = outer
            do_vec(3'd2, 3'd0, '0, 1'b0);        // R3 outer mask
            do_vec(3'd1, 3'd3, cond, 1'b0);      // R4 inactive lanes zero
            do_sc(3'd3, 3'd2, 3'd3);             // R5 save and narrow
            do_sc(3'd6, 3'd0, 3'd0);             // R8 if-side skip test
            do_vec(3'd2, 3'd0, '0, 1'b1);        // R3 then-side, R9 inject
            do_sc(3'd4, 3'd0, 3'd2);             // R6 else side
            do_sc(3'd6, 3'd0, 3'd0);             // R8 else-side skip test
            do_vec(3'd2, 3'd0, '0, 1'b0);        // R3 else-side lanes
            do_vec(3'd1, 3'd4, ~cond, 1'b1);     // R4, R9 during compare
            do_sc(3'd5, 3'd0, 3'd2);             // R7 restore
            do_vec(3'd2, 3'd0, '0, 1'b0);        // R3 restored lanes
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule